// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the two data queues that sit between a processor's register port and an SPI serial engine. Software pushes outgoing words by writing one register index and pops incoming words by reading another. The serial engine takes outgoing words and delivers incoming words through simple one-cycle strobes. The shifting itself lives elsewhere. The block reports the fill level of each queue and a five-bit status word. It keeps sticky error flags for dropped or invalid accesses and derives level-based interrupt conditions from programmable thresholds.

Software sees raw interrupt status and a masked copy, and clears the sticky flags by writing a clear register. Two DMA request lines are raised from separate watermark registers, and each line is gated by its own enable bit. Every threshold and watermark register stores a written value only if that value is below the queue depth. Writing increasing values and reading them back therefore tells software the depth.

The register port is word-indexed with a four-bit index. Index assignments: 0 transmit data (write pushes), 1 receive data (read pops), 2 transmit level, 3 receive level, 4 transmit threshold, 5 receive threshold, 6 status, 7 interrupt mask, 8 raw interrupts, 9 masked interrupts, 10 interrupt clear, 11 DMA enables, 12 transmit watermark, 13 receive watermark. The transmit data, clear and unused indices read as zero.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, both levels read 0, all threshold, watermark, mask and DMA-enable registers read 0, status reads 0x0C, raw interrupts read 0x01, and irq and both DMA requests are low.
- R2: A write to index 0 appends the data to the transmit queue when it is not full. The engine sees the oldest word on eng_tx_data with eng_tx_valid high, and a take strobe removes it. Index 2 reads the entry count.
- R3: A write to index 0 while the transmit queue holds DEPTH entries is dropped and sets raw interrupt bit 1, which stays set until it is cleared.
- R4: An engine put appends eng_rx_data to the receive queue. A read of index 1 returns the oldest entry and removes it. Index 3 reads the entry count.
- R5: A read of index 1 while the receive queue is empty returns 0, leaves the level at 0 and sets sticky raw bit 2.
- R6: An engine put while the receive queue holds DEPTH entries is dropped and sets sticky raw bit 3.
- R7: The threshold and watermark registers (indices 4, 5, 12, 13) store a written value only if it is below DEPTH, and otherwise keep their previous value.
- R8: Raw bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is above the receive threshold.
- R9: Index 9 reads raw AND mask (index 7, bits 4:0), and irq is high exactly when that value is nonzero.
- R10: A write to index 10 clears sticky bits: bit 0 clears raw bits 1–3, bit 1 clears raw bit 2, bit 2 clears raw bit 3, bit 3 clears raw bit 1. A flag that is set in the same cycle as its clear stays set.
- R11: Status bits are: 0 engine busy, 1 transmit full, 2 transmit empty, 3 receive empty, 4 receive full.
- R12: tx_dma_req is high while DMA-enable bit 1 is set and the transmit level is at or below the transmit watermark. rx_dma_req is high while DMA-enable bit 0 is set and the receive level is above the receive watermark.
- R13: reg_rdata shows the value selected by a read in the cycle after reg_rd, and is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| eng_busy | input | 1 | Serial engine busy, reported in status |
| eng_tx_valid | output | 1 | Transmit queue holds a word |
| eng_tx_data | output | DATA_W | Oldest transmit word |
| eng_tx_take | input | 1 | Engine removes the oldest transmit word |
| eng_rx_put | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| irq | output | 1 | OR of masked interrupts |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
A wrong pointer or count does not stay hidden. It shows on eng_tx_data, on the level reads, or on the data a receive read returns within one cycle of the next access. A drift in the count moves the level-derived interrupt and DMA lines on the following clock. Sticky flags that set or clear wrongly show on irq as soon as they are masked in, and in the raw read one cycle after the access. The bench runs a queue-based model next to the block and compares the read data, irq, both DMA lines and the engine-side head word on every clock. A wrong state is therefore flagged in the first cycle it reaches a port.

// File: rtl/spi_fifo_pkg.sv
// Shared definitions for the SPI FIFO status and interrupt unit.
// Assumes a four-bit word index on the register port.
package spi_fifo_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        IDX_TX_DATA  = 4'd0,
        IDX_RX_DATA  = 4'd1,
        IDX_TX_LEVEL = 4'd2,
        IDX_RX_LEVEL = 4'd3,
        IDX_TX_THR   = 4'd4,
        IDX_RX_THR   = 4'd5,
        IDX_STATUS   = 4'd6,
        IDX_MASK     = 4'd7,
        IDX_RAW      = 4'd8,
        IDX_MASKED   = 4'd9,
        IDX_CLEAR    = 4'd10,
        IDX_DMA_EN   = 4'd11,
        IDX_TX_WM    = 4'd12,
        IDX_RX_WM    = 4'd13
    } reg_idx_e;

    // Depth-limited registers, in generate order.
    localparam int NUM_LIM = 4;
    localparam reg_idx_e LIM_SEL [NUM_LIM] = '{IDX_TX_THR, IDX_RX_THR, IDX_TX_WM, IDX_RX_WM};
    localparam int LIM_TX_THR = 0;
    localparam int LIM_RX_THR = 1;
    localparam int LIM_TX_WM  = 2;
    localparam int LIM_RX_WM  = 3;

    // Interrupt bit positions.
    localparam int IRQ_TX_LOW   = 0;
    localparam int IRQ_TX_OVF   = 1;
    localparam int IRQ_RX_UDF   = 2;
    localparam int IRQ_RX_OVF   = 3;
    localparam int IRQ_RX_HIGH  = 4;
    localparam int IRQ_W        = 5;

    // Status bit positions.
    localparam int ST_BUSY     = 0;
    localparam int ST_TX_FULL  = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_RX_EMPTY = 3;
    localparam int ST_RX_FULL  = 4;

    // Clear register bit positions.
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UDF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;
    localparam int CLR_W      = 4;

    // DMA enable bit positions.
    localparam int DMA_RX = 0;
    localparam int DMA_TX = 1;

endpackage

// File: rtl/sfs_fifo.sv
// Synchronous circular queue with an entry counter.
// A push into a full queue and a pop from an empty queue are ignored; the
// caller detects those cases from full/empty. The head word is shown
// combinationally. DEPTH need not be a power of two.
module sfs_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [LVL_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept only legal accesses.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance pointers and entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Present head and flags.
    always_comb begin
        dout  = mem[rd_ptr];
        level = cnt;
        full  = (cnt == LVL_W'(DEPTH));
        empty = (cnt == '0);
    end

    // R3 / R6: a push into a full queue with no pop leaves the count unchanged.
    a_r3_full_push_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == LVL_W'(DEPTH)));

    // R5: a pop from an empty queue with no push keeps the count at zero.
    a_r5_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    // R2 / R4: the count never passes the depth.
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

endmodule

// File: rtl/sfs_limreg.sv
// Register that accepts a written value only when it is below DEPTH.
// Assumes DW is wide enough to hold DEPTH. Resets to zero.
module sfs_limreg #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic [LVL_W-1:0] q
);

    logic accept;

    // Decide whether the write is in range.
    always_comb begin
        accept = wr && (wdata < DW'(DEPTH));
    end

    // Hold the stored limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (accept) begin
            q <= LVL_W'(wdata);
        end
    end

    // R7: an out-of-range write leaves the value unchanged.
    a_r7_keep_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata >= DW'(DEPTH))) |=> $stable(q));

    // R7: the stored value stays below the depth.
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q < LVL_W'(DEPTH));

endmodule

// File: rtl/sfs_irq.sv
// Interrupt state: three sticky error flags plus two level conditions,
// a mask register and the combined request line.
// Assumes set strobes are single-cycle events; a set beats a same-cycle clear.
module sfs_irq
    import spi_fifo_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic             set_tx_ovf,
    input  logic             set_rx_udf,
    input  logic             set_rx_ovf,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_bits,
    input  logic             mask_wr,
    input  logic [IRQ_W-1:0] mask_wdata,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] masked_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic             irq_o
);

    logic             tx_ovf_q;
    logic             rx_udf_q;
    logic             rx_ovf_q;
    logic [IRQ_W-1:0] mask_q;
    logic             clr_tx_ovf;
    logic             clr_rx_udf;
    logic             clr_rx_ovf;

    // Decode which sticky flags a clear write removes.
    always_comb begin
        clr_tx_ovf = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CLR_TX_OVF]);
        clr_rx_udf = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CLR_RX_UDF]);
        clr_rx_ovf = clr_wr && (clr_bits[CLR_ALL] || clr_bits[CLR_RX_OVF]);
    end

    // Sticky error flags; setting has priority over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_udf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            tx_ovf_q <= set_tx_ovf || (tx_ovf_q && !clr_tx_ovf);
            rx_udf_q <= set_rx_udf || (rx_udf_q && !clr_rx_udf);
            rx_ovf_q <= set_rx_ovf || (rx_ovf_q && !clr_rx_ovf);
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    // Assemble raw and masked vectors and the request line.
    always_comb begin
        raw_o              = '0;
        raw_o[IRQ_TX_LOW]  = (tx_level <= tx_thr);
        raw_o[IRQ_TX_OVF]  = tx_ovf_q;
        raw_o[IRQ_RX_UDF]  = rx_udf_q;
        raw_o[IRQ_RX_OVF]  = rx_ovf_q;
        raw_o[IRQ_RX_HIGH] = (rx_level > rx_thr);
        masked_o           = raw_o & mask_q;
        mask_o             = mask_q;
        irq_o              = |masked_o;
    end

    // R10: a set in the same cycle as a clear-all still leaves the flag high.
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set_rx_ovf |=> raw_o[IRQ_RX_OVF]);

    // R10: clear-all with no competing set drops the transmit overflow flag.
    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[CLR_ALL] && !set_tx_ovf) |=> !raw_o[IRQ_TX_OVF]);

    // R9: with nothing masked in, the request line stays low.
    a_r9_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/spi_fifo_irq_unit.sv
// Top of the SPI FIFO status and interrupt unit. Decodes the word-indexed
// register port, joins the transmit and receive queues to the serial engine
// strobes, and drives interrupt and DMA request lines.
// Assumes reg_wr and reg_rd are not asserted together and DATA_W >= LVL_W.
module spi_fifo_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_busy,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_put,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);

    logic              tx_push;
    logic              rx_pop;
    logic [LVL_W-1:0]  tx_level;
    logic [LVL_W-1:0]  rx_level;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_full;
    logic              rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [LVL_W-1:0]  lim_q [NUM_LIM];
    logic [IRQ_W-1:0]  raw;
    logic [IRQ_W-1:0]  masked;
    logic [IRQ_W-1:0]  mask;
    logic [1:0]        dma_en_q;
    logic [4:0]        status;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // Register-port access decode.
    always_comb begin
        tx_push = reg_wr && (reg_addr == IDX_TX_DATA);
        rx_pop  = reg_rd && (reg_addr == IDX_RX_DATA);
    end

    sfs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .din   (reg_wdata),
        .pop   (eng_tx_take),
        .dout  (eng_tx_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfs_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (eng_rx_put),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // One depth-limited register per threshold and watermark.
    for (genvar gi = 0; gi < NUM_LIM; gi++) begin : g_lim
        sfs_limreg #(.DW(DATA_W), .DEPTH(DEPTH)) u_lim (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr && (reg_addr == LIM_SEL[gi])),
            .wdata (reg_wdata),
            .q     (lim_q[gi])
        );
    end

    sfs_irq #(.LVL_W(LVL_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .tx_thr     (lim_q[LIM_TX_THR]),
        .rx_thr     (lim_q[LIM_RX_THR]),
        .set_tx_ovf (tx_push && tx_full),
        .set_rx_udf (rx_pop && rx_empty),
        .set_rx_ovf (eng_rx_put && rx_full),
        .clr_wr     (reg_wr && (reg_addr == IDX_CLEAR)),
        .clr_bits   (reg_wdata[CLR_W-1:0]),
        .mask_wr    (reg_wr && (reg_addr == IDX_MASK)),
        .mask_wdata (reg_wdata[IRQ_W-1:0]),
        .raw_o      (raw),
        .masked_o   (masked),
        .mask_o     (mask),
        .irq_o      (irq)
    );

    // DMA enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en_q <= '0;
        end else if (reg_wr && (reg_addr == IDX_DMA_EN)) begin
            dma_en_q <= reg_wdata[1:0];
        end
    end

    // DMA requests from levels against watermarks.
    always_comb begin
        tx_dma_req = dma_en_q[DMA_TX] && (tx_level <= lim_q[LIM_TX_WM]);
        rx_dma_req = dma_en_q[DMA_RX] && (rx_level >  lim_q[LIM_RX_WM]);
    end

    // Status word assembly.
    always_comb begin
        status              = '0;
        status[ST_BUSY]     = eng_busy;
        status[ST_TX_FULL]  = tx_full;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_RX_EMPTY] = rx_empty;
        status[ST_RX_FULL]  = rx_full;
    end

    // Read-data selection by word index.
    always_comb begin
        case (reg_addr)
            IDX_RX_DATA:  rd_mux = rx_empty ? '0 : rx_head;
            IDX_TX_LEVEL: rd_mux = DATA_W'(tx_level);
            IDX_RX_LEVEL: rd_mux = DATA_W'(rx_level);
            IDX_TX_THR:   rd_mux = DATA_W'(lim_q[LIM_TX_THR]);
            IDX_RX_THR:   rd_mux = DATA_W'(lim_q[LIM_RX_THR]);
            IDX_STATUS:   rd_mux = DATA_W'(status);
            IDX_MASK:     rd_mux = DATA_W'(mask);
            IDX_RAW:      rd_mux = DATA_W'(raw);
            IDX_MASKED:   rd_mux = DATA_W'(masked);
            IDX_DMA_EN:   rd_mux = DATA_W'(dma_en_q);
            IDX_TX_WM:    rd_mux = DATA_W'(lim_q[LIM_TX_WM]);
            IDX_RX_WM:    rd_mux = DATA_W'(lim_q[LIM_RX_WM]);
            default:      rd_mux = '0;
        endcase
    end

    // Registered read data; zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= reg_rd ? rd_mux : '0;
        end
    end

    always_comb begin
        reg_rdata    = rdata_q;
        eng_tx_valid = !tx_empty;
    end

    // R13: read data is zero after a cycle without a read.
    a_r13_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));

    // R5: a receive read from an empty queue returns zero.
    a_r5_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> (reg_rdata == '0));

    // R12: the transmit request is silent while its enable is off.
    a_r12_tx_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_q[DMA_TX] |-> !tx_dma_req);

    // R12: the receive request is silent while its enable is off.
    a_r12_rx_dma_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_q[DMA_RX] |-> !rx_dma_req);

endmodule

// File: tb/spi_fifo_irq_unit_test.sv
// Bench for spi_fifo_irq_unit: queue-based reference model compared on
// every clock, plus directed checks per requirement.
module spi_fifo_irq_unit_test;

    localparam int DW = 16;
    localparam int D  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          eng_busy = 1'b0;
    logic          eng_tx_valid;
    logic [DW-1:0] eng_tx_data;
    logic          eng_tx_take = 1'b0;
    logic          eng_rx_put = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          irq;
    logic          tx_dma_req;
    logic          rx_dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_fifo_irq_unit #(.DATA_W(DW), .DEPTH(D)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .eng_busy     (eng_busy),
        .eng_tx_valid (eng_tx_valid),
        .eng_tx_data  (eng_tx_data),
        .eng_tx_take  (eng_tx_take),
        .eng_rx_put   (eng_rx_put),
        .eng_rx_data  (eng_rx_data),
        .irq          (irq),
        .tx_dma_req   (tx_dma_req),
        .rx_dma_req   (rx_dma_req)
    );

    // ---------------- reference model ----------------
    logic [DW-1:0] txq [$];
    logic [DW-1:0] rxq [$];
    int            m_thr_tx, m_thr_rx, m_wm_tx, m_wm_rx;
    logic [4:0]    m_mask;
    logic [4:0]    m_sticky;
    logic [1:0]    m_dma;
    logic [DW-1:0] m_rdata;

    function automatic logic [4:0] m_raw();
        logic [4:0] r;
        r    = m_sticky & 5'b01110;
        r[0] = (txq.size() <= m_thr_tx);
        r[4] = (rxq.size() > m_thr_rx);
        return r;
    endfunction

    function automatic logic [DW-1:0] m_read(input logic [3:0] a);
        logic [4:0] st;
        st = {rxq.size() == D, rxq.size() == 0, txq.size() == 0, txq.size() == D, eng_busy};
        case (a)
            4'd1:    return (rxq.size() > 0) ? rxq[0] : '0;
            4'd2:    return DW'(txq.size());
            4'd3:    return DW'(rxq.size());
            4'd4:    return DW'(m_thr_tx);
            4'd5:    return DW'(m_thr_rx);
            4'd6:    return DW'(st);
            4'd7:    return DW'(m_mask);
            4'd8:    return DW'(m_raw());
            4'd9:    return DW'(m_raw() & m_mask);
            4'd11:   return DW'(m_dma);
            4'd12:   return DW'(m_wm_tx);
            4'd13:   return DW'(m_wm_rx);
            default: return '0;
        endcase
    endfunction

    // Model update on each rising edge from the inputs driven since the last fall.
    always @(posedge clk) begin
        int         txl, rxl;
        logic [4:0] setb, clrb;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_thr_tx = 0; m_thr_rx = 0; m_wm_tx = 0; m_wm_rx = 0;
            m_mask = '0; m_sticky = '0; m_dma = '0; m_rdata = '0;
        end else begin
            txl = txq.size();
            rxl = rxq.size();
            m_rdata = reg_rd ? m_read(reg_addr) : '0;
            setb = '0;
            clrb = '0;
            if (reg_wr && reg_addr == 4'd0 && txl == D) setb[1] = 1'b1;
            if (reg_rd && reg_addr == 4'd1 && rxl == 0) setb[2] = 1'b1;
            if (eng_rx_put && rxl == D)                 setb[3] = 1'b1;
            if (reg_wr && reg_addr == 4'd10) begin
                if (reg_wdata[0]) clrb = 5'b01110;
                if (reg_wdata[1]) clrb[2] = 1'b1;
                if (reg_wdata[2]) clrb[3] = 1'b1;
                if (reg_wdata[3]) clrb[1] = 1'b1;
            end
            m_sticky = (m_sticky & ~clrb) | setb;
            if (eng_tx_take && txl > 0) void'(txq.pop_front());
            if (reg_wr && reg_addr == 4'd0 && txl < D) txq.push_back(reg_wdata);
            if (reg_rd && reg_addr == 4'd1 && rxl > 0) void'(rxq.pop_front());
            if (eng_rx_put && rxl < D) rxq.push_back(eng_rx_data);
            if (reg_wr) begin
                case (reg_addr)
                    4'd4:  if (reg_wdata < D) m_thr_tx = int'(reg_wdata);
                    4'd5:  if (reg_wdata < D) m_thr_rx = int'(reg_wdata);
                    4'd12: if (reg_wdata < D) m_wm_tx  = int'(reg_wdata);
                    4'd13: if (reg_wdata < D) m_wm_rx  = int'(reg_wdata);
                    4'd7:  m_mask = reg_wdata[4:0];
                    4'd11: m_dma  = reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R13 read data", 32'(reg_rdata), 32'(m_rdata));
            chk("R9 irq line", 32'(irq), 32'(|(m_raw() & m_mask)));
            chk("R12 tx dma", 32'(tx_dma_req), 32'(m_dma[1] && txq.size() <= m_wm_tx));
            chk("R12 rx dma", 32'(rx_dma_req), 32'(m_dma[0] && rxq.size() > m_wm_rx));
            chk("R2 tx valid", 32'(eng_tx_valid), 32'(txq.size() > 0));
            if (txq.size() > 0) chk("R2 tx head", 32'(eng_tx_data), 32'(txq[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] v;
        rd(a, v);
        chk(req, 32'(v), 32'(exp));
    endtask

    task automatic take();
        eng_tx_take = 1'b1;
        @(negedge clk);
        eng_tx_take = 1'b0;
    endtask

    task automatic put(input logic [DW-1:0] d);
        eng_rx_put = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_put = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        int found;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_expect(4'd6, 16'h000C, "R1 status after reset");
        rd_expect(4'd8, 16'h0001, "R1 raw after reset");
        rd_expect(4'd2, 16'h0000, "R1 tx level after reset");
        rd_expect(4'd3, 16'h0000, "R1 rx level after reset");
        rd_expect(4'd11, 16'h0000, "R1 dma enables after reset");
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 dma lines after reset", 32'({tx_dma_req, rx_dma_req}), 32'd0);

        // R7 depth discovery by write and read-back
        found = 0;
        for (int k = 1; k < 32; k++) begin
            wr(4'd4, DW'(k));
            rd(4'd4, v);
            if (found == 0 && int'(v) != k) found = k;
        end
        chk("R7 discovered depth", 32'(found), 32'(D));
        wr(4'd4, 16'd100);
        rd_expect(4'd4, 16'd15, "R7 out-of-range write kept old value");
        wr(4'd13, 16'd16);
        rd_expect(4'd13, 16'd0, "R7 watermark rejects depth");
        wr(4'd4, 16'd3);

        // R2 transmit path ordering and level
        for (int k = 0; k < 5; k++) wr(4'd0, DW'(16'hA0 + k));
        rd_expect(4'd2, 16'd5, "R2 tx level after five pushes");
        chk("R2 head word", 32'(eng_tx_data), 32'h00A0);
        take();
        take();
        chk("R2 head after two takes", 32'(eng_tx_data), 32'h00A2);
        rd_expect(4'd8, 16'h0001, "R8 tx level at threshold");

        // R3 / R11 fill transmit queue and overflow it
        for (int k = 0; k < 13; k++) wr(4'd0, DW'(16'hB0 + k));
        rd_expect(4'd6, 16'h000A, "R11 status with tx full");
        wr(4'd0, 16'hFFFF);
        rd_expect(4'd8, 16'h0002, "R3 overflow flag raised");
        rd_expect(4'd2, 16'd16, "R3 level unchanged by dropped write");

        // R9 masking and R10 selective clear
        wr(4'd7, 16'h0002);
        chk("R9 irq with overflow masked in", 32'(irq), 32'd1);
        rd_expect(4'd9, 16'h0002, "R9 masked status");
        wr(4'd10, 16'h0008);
        rd_expect(4'd8, 16'h0000, "R10 tx overflow cleared");
        chk("R9 irq after clear", 32'(irq), 32'd0);
        for (int k = 0; k < 16; k++) take();
        rd_expect(4'd2, 16'd0, "R2 tx drained");
        chk("R3 dropped word never reached engine", 32'(eng_tx_valid), 32'd0);

        // R4 receive ordering
        put(16'h0011); put(16'h0022); put(16'h0033);
        rd_expect(4'd3, 16'd3, "R4 rx level");
        rd_expect(4'd1, 16'h0011, "R4 first rx word");
        rd_expect(4'd1, 16'h0022, "R4 second rx word");
        rd_expect(4'd1, 16'h0033, "R4 third rx word");

        // R5 underflow
        rd_expect(4'd1, 16'h0000, "R5 empty read returns zero");
        rd_expect(4'd8, 16'h0005, "R5 underflow flag raised");
        rd_expect(4'd3, 16'd0, "R5 level stays zero");
        wr(4'd10, 16'h0002);
        rd_expect(4'd8, 16'h0001, "R10 underflow cleared");

        // R8 receive threshold
        wr(4'd5, 16'd4);
        for (int k = 0; k < 4; k++) put(DW'(16'hC0 + k));
        rd_expect(4'd8, 16'h0001, "R8 rx level equal to threshold");
        put(16'h00C4);
        rd_expect(4'd8, 16'h0011, "R8 rx level above threshold");

        // R6 overflow with a same-cycle clear: set wins (R10)
        for (int k = 0; k < 11; k++) put(DW'(16'hD0 + k));
        rd_expect(4'd6, 16'h0014, "R11 status with rx full");
        eng_rx_put = 1'b1; eng_rx_data = 16'hEEEE;
        reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 16'h0004;
        @(negedge clk);
        eng_rx_put = 1'b0; reg_wr = 1'b0;
        rd_expect(4'd8, 16'h0019, "R6 R10 overflow set beats clear");
        rd_expect(4'd3, 16'd16, "R6 dropped put leaves level");
        wr(4'd10, 16'h0001);
        rd_expect(4'd8, 16'h0011, "R10 clear all");
        for (int k = 0; k < 16; k++) rd(4'd1, v);
        chk("R6 last word is last accepted", 32'(v), 32'h00DA);

        // R12 DMA requests
        wr(4'd12, 16'd2);
        wr(4'd13, 16'd1);
        chk("R12 tx request off when disabled", 32'(tx_dma_req), 32'd0);
        wr(4'd11, 16'h0003);
        chk("R12 tx request at low level", 32'(tx_dma_req), 32'd1);
        chk("R12 rx request with empty rx", 32'(rx_dma_req), 32'd0);
        put(16'h0001); put(16'h0002);
        chk("R12 rx request above watermark", 32'(rx_dma_req), 32'd1);
        wr(4'd0, 16'h1); wr(4'd0, 16'h2); wr(4'd0, 16'h3);
        chk("R12 tx request above watermark", 32'(tx_dma_req), 32'd0);
        wr(4'd11, 16'h0001);
        chk("R12 rx request with only rx enabled", 32'(rx_dma_req), 32'd1);

        // R11 busy bit, R13 unmapped index
        eng_busy = 1'b1;
        rd_expect(4'd6, 16'h0001, "R11 busy reported");
        eng_busy = 1'b0;
        rd_expect(4'd15, 16'h0000, "R13 unmapped index reads zero");

        // Mixed traffic compared against the model every clock
        for (int k = 0; k < 600; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            eng_tx_take = ($urandom_range(0, 2) == 0);
            eng_rx_put  = ($urandom_range(0, 2) == 0);
            eng_rx_data = DW'($urandom);
            eng_busy    = $urandom_range(0, 1) == 1;
            reg_wr = 1'b0; reg_rd = 1'b0;
            case (op)
                0, 1: begin reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = DW'($urandom); end
                2, 3: begin reg_rd = 1'b1; reg_addr = 4'd1; end
                4:    begin reg_rd = 1'b1; reg_addr = 4'($urandom_range(0, 15)); end
                5:    begin reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = DW'($urandom_range(0, 15)); end
                6:    begin reg_wr = 1'b1; reg_addr = 4'($urandom_range(4, 5)); reg_wdata = DW'($urandom_range(0, 20)); end
                7:    begin reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = DW'($urandom_range(0, 31)); end
                8:    begin reg_wr = 1'b1; reg_addr = 4'($urandom_range(12, 13)); reg_wdata = DW'($urandom_range(0, 20)); end
                default: ;
            endcase
            @(negedge clk);
        end
        reg_wr = 1'b0; reg_rd = 1'b0; eng_tx_take = 1'b0; eng_rx_put = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule